// File: doc/BRIEF.md
# Stop-Mode Debug Execution Controller

This block sits beside a pipelined CPU core and decides, every cycle, whether the instruction packet waiting at the entrance of the second decode stage may move forward and whether a pending interrupt may be accepted. It follows debugger commands (halt, run, single-step) and break events: a user halt request, a program-address breakpoint match, a breakpoint opcode seen at decode, a watchpoint request and an external halt trigger. Any of these stops execution at the next packet boundary and parks the core in a debug-halt state. While halted, no interrupt of any kind is accepted. Each source keeps one pending bit, so repeated requests during a halt collapse into one.

Leaving debug-halt, the core can run normally, run in a mode that ignores all later break events (selected by running while stop mode is disabled), wait for a global synchronization strobe before it starts, or execute exactly one packet and fall back to the halt. During a single step, interrupts pass only if the step command carried the interrupt-enable flag. In normal run, a debug event that coincides with an interrupt wins. A debug event that arrives while interrupt entry is already under way waits until the service routine begins.

Top module: `dbg_exec_ctrl`

## Requirements
- R1: While reset is low, the controller enters debug-halt if `stop_en` is high and free-run if it is low. Halted: `halted`=1, `adv_en`=0. Free-run: `halted`=0, `adv_en`=1.
- R2: In run, a pulse on any of `cmd_halt`, `ev_hw_bp`, `ev_sw_bp`, `ev_watch`, `ev_ext_trig` while `isr_busy`=0 makes `halted` high from the next cycle on.
- R3: In run, `ev_hw_bp` or `ev_sw_bp` forces `adv_en` low in the same cycle, so the flagged packet does not advance.
- R4: In debug-halt, `adv_en` and `irq_grant` are zero. Requests still set one pending bit per source, and several requests from one source during the halt produce a single grant after the core runs again.
- R5: In single-step, `adv_en` stays high until a cycle with `pkt_valid`=1. The controller then returns to debug-halt, and `step_done` is high for exactly the first halted cycle.
- R6: In single-step, interrupts are granted only if `step_int_en` was high in the cycle the step command was taken. Otherwise `irq_grant` stays zero.
- R7: In run, pending interrupts are granted. In a cycle with a break event, `irq_gate` and `irq_grant` are zero and the event leads to the halt.
- R8: In run, a break event seen while `isr_busy`=1 is held. The halt happens in the first cycle with `isr_busy`=0: `adv_en` is low in that cycle and `halted` is high in the next.
- R9: A run command with `stop_en` low enters free-run. There, breakpoints, watchpoints and triggers do not affect `adv_en` or `halted`, and interrupts are granted.
- R10: A run command with `sync_cfg` high enters a wait state with `adv_en`=0 and `halted`=0. The next cycle after a `sync_strobe` pulse is in run with `adv_en`=1.
- R11: `cmd_halt` moves the controller to debug-halt from run, free-run, single-step and the sync wait. In debug-halt it changes nothing.
- R12: `irq_grant` has at most one bit set, and that bit is the lowest-numbered pending source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_en | input | 1 | Stop-mode debug enable (level) |
| sync_cfg | input | 1 | Run commands wait for the sync strobe (level) |
| cmd_halt | input | 1 | Debugger halt request (pulse) |
| cmd_run | input | 1 | Debugger run command (pulse) |
| cmd_step | input | 1 | Debugger single-step command (pulse) |
| step_int_en | input | 1 | Interrupt enable sampled with the step command |
| sync_strobe | input | 1 | Global synchronization strobe |
| ev_hw_bp | input | 1 | Program-address breakpoint match for the packet at decode |
| ev_sw_bp | input | 1 | Breakpoint opcode seen in the packet at decode |
| ev_watch | input | 1 | Watchpoint request |
| ev_ext_trig | input | 1 | External halt trigger |
| pkt_valid | input | 1 | A packet is ready to enter the second decode stage |
| irq_req | input | N_IRQ | Interrupt request per source |
| isr_busy | input | 1 | Interrupt entry has started and the routine has not begun |
| adv_en | output | 1 | Pipeline-advance enable into the second decode stage |
| irq_gate | output | 1 | Interrupt acceptance window open |
| irq_grant | output | N_IRQ | One-hot grant of the accepted source |
| halted | output | 1 | High only in debug-halt |
| step_done | output | 1 | One-cycle pulse when a single step returns to halt |

## Verification
The bench targets the cycle in which a break event arrives together with something else. A breakpoint that blocks the advance one cycle late lets the flagged packet through. An interrupt granted in the same cycle as a watchpoint shows that the arbitration is inverted. A halt taken while `isr_busy` is high would cut off interrupt entry. The bench also sends repeated requests during a halt, where a counter in place of a single bit would grant the source twice. It runs single-steps with the enable flag both clear and set, and with a delayed `pkt_valid`, to expose a step that consumes no packet or leaks interrupts. It drives break events during free-run and during the sync wait, where an incomplete state decode would halt the core or let it advance early.

// File: rtl/dbg_exec_pkg.sv
// Shared types for the stop-mode debug execution controller.
// Assumes: all users compile this package first.
package dbg_exec_pkg;

    // Execution states of the controller.
    typedef enum logic [2:0] {
        ST_HALT  = 3'd0,
        ST_STEP  = 3'd1,
        ST_RUN   = 3'd2,
        ST_SYNCW = 3'd3,
        ST_FREE  = 3'd4
    } dbg_state_e;

    // Collected break sources that can stop execution in run.
    typedef struct packed {
        logic user_halt;
        logic hw_bp;
        logic sw_bp;
        logic watch;
        logic ext_trig;
    } brk_ev_t;

endpackage

// File: rtl/dbg_event_arb.sv
// Break-event arbiter: decides when a run must end in debug-halt.
// Combines the break sources, postpones the halt while interrupt entry
// is in progress, and says whether interrupts may be accepted in run.
// Assumes: in_run is high only while the controller is in the run state.
module dbg_event_arb
    import dbg_exec_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_run,
    input  brk_ev_t brk_ev,
    input  logic    isr_busy,
    output logic    take_halt,
    output logic    bp_block,
    output logic    run_irq_ok
);

    logic brk_now;
    logic defer_q;

    // Detect any break source while running.
    always_comb begin
        brk_now  = in_run && (|brk_ev);
        bp_block = in_run && (brk_ev.hw_bp || brk_ev.sw_bp);
    end

    // Halt now unless interrupt entry is under way; open irqs only when calm.
    always_comb begin
        take_halt  = in_run && (brk_now || defer_q) && !isr_busy;
        run_irq_ok = in_run && !brk_now && !defer_q;
    end

    // Remember a break event that arrived during interrupt entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            defer_q <= 1'b0;
        end else if (!in_run || take_halt) begin
            defer_q <= 1'b0;
        end else if (brk_now && isr_busy) begin
            defer_q <= 1'b1;
        end
    end

endmodule

// File: rtl/dbg_irq_gate.sv
// Interrupt gate: one pending bit per source and a fixed-priority grant.
// A request that finds its bit already set is lost. Lower index wins.
// Assumes: irq_req bits are single-cycle pulses or levels; a level re-arms
// its bit each cycle.
module dbg_irq_gate #(
    parameter int unsigned N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             gate_open,
    output logic [N_IRQ-1:0] irq_grant
);

    logic [N_IRQ-1:0] pend_q;
    logic [N_IRQ-1:0] first_pend;

    // Pick the lowest-numbered pending source.
    always_comb begin
        logic found;
        found      = 1'b0;
        first_pend = '0;
        for (int i = 0; i < int'(N_IRQ); i++) begin
            if (!found && pend_q[i]) begin
                first_pend[i] = 1'b1;
                found         = 1'b1;
            end
        end
    end

    // Grant only while the window is open.
    always_comb begin
        irq_grant = gate_open ? first_pend : '0;
    end

    // Clear the granted bit, then collect new requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~irq_grant) | irq_req;
        end
    end

endmodule

// File: rtl/dbg_exec_fsm.sv
// Execution-state machine: halt, step, run, sync wait and free-run.
// Drives the pipeline-advance enable, the interrupt window, the halted
// flag and the step-done pulse.
// Assumes: debugger commands are single-cycle pulses; stop_en and sync_cfg
// are levels read when a run command or reset is taken.
module dbg_exec_fsm
    import dbg_exec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_en,
    input  logic       sync_cfg,
    input  logic       cmd_halt,
    input  logic       cmd_run,
    input  logic       cmd_step,
    input  logic       step_int_en,
    input  logic       sync_strobe,
    input  logic       pkt_valid,
    input  logic       take_halt,
    input  logic       bp_block,
    input  logic       run_irq_ok,
    output dbg_state_e st,
    output logic       step_ie_q,
    output logic       adv_en,
    output logic       gate_open,
    output logic       halted,
    output logic       step_done
);

    dbg_state_e st_q;
    dbg_state_e st_d;
    logic       step_fin;

    // A step ends when its one packet advances (a halt command overrides it).
    always_comb begin
        step_fin = (st_q == ST_STEP) && !cmd_halt && pkt_valid;
    end

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HALT: begin
                if (cmd_run) begin
                    if (!stop_en)      st_d = ST_FREE;
                    else if (sync_cfg) st_d = ST_SYNCW;
                    else               st_d = ST_RUN;
                end else if (cmd_step) begin
                    st_d = ST_STEP;
                end
            end
            ST_STEP: begin
                if (cmd_halt || step_fin) st_d = ST_HALT;
            end
            ST_RUN: begin
                if (take_halt) st_d = ST_HALT;
            end
            ST_SYNCW: begin
                if (cmd_halt)         st_d = ST_HALT;
                else if (sync_strobe) st_d = ST_RUN;
            end
            ST_FREE: begin
                if (cmd_halt) st_d = ST_HALT;
            end
            default: st_d = ST_HALT;
        endcase
    end

    // State register; reset picks halt or free-run from stop_en.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= stop_en ? ST_HALT : ST_FREE;
        end else begin
            st_q <= st_d;
        end
    end

    // Latch the step's interrupt permission when a step command is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_ie_q <= 1'b0;
        end else if (st_q == ST_HALT && !cmd_run && cmd_step) begin
            step_ie_q <= step_int_en;
        end
    end

    // One-cycle pulse on the first halted cycle after a completed step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_done <= 1'b0;
        end else begin
            step_done <= step_fin;
        end
    end

    // Pipeline-advance enable per state.
    always_comb begin
        unique case (st_q)
            ST_RUN:  adv_en = !(take_halt || bp_block);
            ST_STEP: adv_en = !cmd_halt;
            ST_FREE: adv_en = !cmd_halt;
            default: adv_en = 1'b0;
        endcase
    end

    // Interrupt window per state.
    always_comb begin
        unique case (st_q)
            ST_RUN:  gate_open = run_irq_ok;
            ST_STEP: gate_open = step_ie_q && !cmd_halt;
            ST_FREE: gate_open = !cmd_halt;
            default: gate_open = 1'b0;
        endcase
    end

    // Halted status and state export.
    always_comb begin
        halted = (st_q == ST_HALT);
        st     = st_q;
    end

endmodule

// File: rtl/dbg_exec_ctrl.sv
// Top of the stop-mode debug execution controller. Connects the break-event
// arbiter, the execution-state machine and the interrupt gate.
// Assumes: break-event inputs refer to the packet currently at the entrance
// of the second decode stage, or to the current cycle for asynchronous sources.
module dbg_exec_ctrl
    import dbg_exec_pkg::*;
#(
    parameter int unsigned N_IRQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_en,
    input  logic             sync_cfg,
    input  logic             cmd_halt,
    input  logic             cmd_run,
    input  logic             cmd_step,
    input  logic             step_int_en,
    input  logic             sync_strobe,
    input  logic             ev_hw_bp,
    input  logic             ev_sw_bp,
    input  logic             ev_watch,
    input  logic             ev_ext_trig,
    input  logic             pkt_valid,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             isr_busy,
    output logic             adv_en,
    output logic             irq_gate,
    output logic [N_IRQ-1:0] irq_grant,
    output logic             halted,
    output logic             step_done
);

    dbg_state_e st;
    brk_ev_t    brk_ev;
    logic       take_halt;
    logic       bp_block;
    logic       run_irq_ok;
    logic       step_ie_q;
    logic       gate_open;

    // Gather the break sources.
    always_comb begin
        brk_ev.user_halt = cmd_halt;
        brk_ev.hw_bp     = ev_hw_bp;
        brk_ev.sw_bp     = ev_sw_bp;
        brk_ev.watch     = ev_watch;
        brk_ev.ext_trig  = ev_ext_trig;
    end

    dbg_event_arb u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_run     (st == ST_RUN),
        .brk_ev     (brk_ev),
        .isr_busy   (isr_busy),
        .take_halt  (take_halt),
        .bp_block   (bp_block),
        .run_irq_ok (run_irq_ok)
    );

    dbg_exec_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_en     (stop_en),
        .sync_cfg    (sync_cfg),
        .cmd_halt    (cmd_halt),
        .cmd_run     (cmd_run),
        .cmd_step    (cmd_step),
        .step_int_en (step_int_en),
        .sync_strobe (sync_strobe),
        .pkt_valid   (pkt_valid),
        .take_halt   (take_halt),
        .bp_block    (bp_block),
        .run_irq_ok  (run_irq_ok),
        .st          (st),
        .step_ie_q   (step_ie_q),
        .adv_en      (adv_en),
        .gate_open   (gate_open),
        .halted      (halted),
        .step_done   (step_done)
    );

    dbg_irq_gate #(.N_IRQ(N_IRQ)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req   (irq_req),
        .gate_open (gate_open),
        .irq_grant (irq_grant)
    );

    // Export the interrupt window.
    always_comb begin
        irq_gate = gate_open;
    end

endmodule

// File: rtl/dbg_exec_ctrl_chk.sv
// Checker for the debug execution controller, bound to the top module.
// Assumes: connected through the bind at the bottom of this file.
module dbg_exec_ctrl_chk
    import dbg_exec_pkg::*;
#(
    parameter int unsigned N_IRQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input dbg_state_e       st,
    input logic             step_ie_q,
    input logic             cmd_halt,
    input logic             ev_hw_bp,
    input logic             ev_sw_bp,
    input logic             ev_watch,
    input logic             ev_ext_trig,
    input logic             isr_busy,
    input logic             adv_en,
    input logic [N_IRQ-1:0] irq_grant,
    input logic             halted,
    input logic             step_done
);

    logic any_ev;
    assign any_ev = cmd_halt || ev_hw_bp || ev_sw_bp || ev_watch || ev_ext_trig;

    p_halt_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!adv_en && irq_grant == '0));

    p_bp_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && (ev_hw_bp || ev_sw_bp)) |-> !adv_en);

    p_break_halts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && any_ev && !isr_busy) |=> halted);

    p_event_beats_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && any_ev) |-> (irq_grant == '0));

    p_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && isr_busy) |=> !halted);

    p_step_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> (halted && $past(st) == ST_STEP));

    p_step_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);

    p_step_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STEP && !step_ie_q) |-> (irq_grant == '0));

    p_free_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FREE && !cmd_halt) |=> (st == ST_FREE));

    p_sync_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SYNCW) |-> (!adv_en && !halted && irq_grant == '0));

    p_halt_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_halt && st != ST_RUN) |=> halted);

    p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_grant));

endmodule

bind dbg_exec_ctrl dbg_exec_ctrl_chk #(.N_IRQ(N_IRQ)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .st          (st),
    .step_ie_q   (step_ie_q),
    .cmd_halt    (cmd_halt),
    .ev_hw_bp    (ev_hw_bp),
    .ev_sw_bp    (ev_sw_bp),
    .ev_watch    (ev_watch),
    .ev_ext_trig (ev_ext_trig),
    .isr_busy    (isr_busy),
    .adv_en      (adv_en),
    .irq_grant   (irq_grant),
    .halted      (halted),
    .step_done   (step_done)
);

// File: tb/dbg_exec_ctrl_test.sv
// Directed bench for the debug execution controller, one task per scenario.
module dbg_exec_ctrl_test;

    localparam int unsigned N_IRQ = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stop_en = 1'b1;
    logic             sync_cfg = 1'b0;
    logic             cmd_halt = 1'b0;
    logic             cmd_run = 1'b0;
    logic             cmd_step = 1'b0;
    logic             step_int_en = 1'b0;
    logic             sync_strobe = 1'b0;
    logic             ev_hw_bp = 1'b0;
    logic             ev_sw_bp = 1'b0;
    logic             ev_watch = 1'b0;
    logic             ev_ext_trig = 1'b0;
    logic             pkt_valid = 1'b0;
    logic [N_IRQ-1:0] irq_req = '0;
    logic             isr_busy = 1'b0;
    logic             adv_en;
    logic             irq_gate;
    logic [N_IRQ-1:0] irq_grant;
    logic             halted;
    logic             step_done;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dbg_exec_ctrl #(.N_IRQ(N_IRQ)) uut (
        .clk(clk), .rst_n(rst_n), .stop_en(stop_en), .sync_cfg(sync_cfg),
        .cmd_halt(cmd_halt), .cmd_run(cmd_run), .cmd_step(cmd_step),
        .step_int_en(step_int_en), .sync_strobe(sync_strobe),
        .ev_hw_bp(ev_hw_bp), .ev_sw_bp(ev_sw_bp), .ev_watch(ev_watch),
        .ev_ext_trig(ev_ext_trig), .pkt_valid(pkt_valid), .irq_req(irq_req),
        .isr_busy(isr_busy), .adv_en(adv_en), .irq_gate(irq_gate),
        .irq_grant(irq_grant), .halted(halted), .step_done(step_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance past the next rising edge and settle.
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic clr();
        cmd_halt = 0; cmd_run = 0; cmd_step = 0; sync_strobe = 0;
        ev_hw_bp = 0; ev_sw_bp = 0; ev_watch = 0; ev_ext_trig = 0;
        pkt_valid = 0; irq_req = '0;
    endtask

    task automatic go_run();
        cmd_run = 1; cyc(); clr();
    endtask

    task automatic go_halt();
        cmd_halt = 1; cyc(); clr();
    endtask

    task automatic do_reset(input logic se);
        stop_en = se; rst_n = 0; clr();
        cyc(); cyc();
        rst_n = 1; #1;
    endtask

    task automatic t_reset_free();
        do_reset(1'b0);
        chk("R1 free halted", int'(halted), 0);
        chk("R1 free adv_en", int'(adv_en), 1);
        ev_hw_bp = 1; ev_watch = 1; #1;
        chk("R9 bp in free adv_en", int'(adv_en), 1);
        cyc(); clr();
        chk("R9 bp in free halted", int'(halted), 0);
        go_halt();
        chk("R11 halt from free", int'(halted), 1);
    endtask

    task automatic t_reset_halt();
        do_reset(1'b1);
        chk("R1 halt halted", int'(halted), 1);
        chk("R1 halt adv_en", int'(adv_en), 0);
    endtask

    task automatic t_halt_irq();
        irq_req = 4'b0100; #1;
        chk("R4 no grant in halt", int'(irq_grant), 0);
        cyc(); irq_req = 4'b0100; cyc(); clr(); #1;
        chk("R4 no adv in halt", int'(adv_en), 0);
        go_run(); #1;
        chk("R4 single grant after run", int'(irq_grant), 4);
        cyc();
        chk("R4 no second instance", int'(irq_grant), 0);
        go_halt();
    endtask

    task automatic t_break();
        for (int k = 0; k < 5; k++) begin
            go_run();
            case (k)
                0: cmd_halt = 1;
                1: ev_hw_bp = 1;
                2: ev_sw_bp = 1;
                3: ev_watch = 1;
                default: ev_ext_trig = 1;
            endcase
            #1;
            if (k == 1 || k == 2) chk("R3 bp blocks adv", int'(adv_en), 0);
            cyc(); clr();
            chk("R2 break halts", int'(halted), 1);
        end
    endtask

    task automatic t_collision();
        irq_req = 4'b0001; cyc(); clr();
        go_run();
        ev_watch = 1; #1;
        chk("R7 event closes gate", int'(irq_gate), 0);
        chk("R7 event beats irq", int'(irq_grant), 0);
        cyc(); clr();
        chk("R7 event halted", int'(halted), 1);
        go_run(); #1;
        chk("R7 irq served in run", int'(irq_grant), 1);
        cyc();
        go_halt();
    endtask

    task automatic t_defer();
        go_run();
        isr_busy = 1; ev_watch = 1; #1;
        cyc(); clr();
        chk("R8 halt held", int'(halted), 0);
        cyc();
        chk("R8 still held", int'(halted), 0);
        isr_busy = 0; #1;
        chk("R8 adv low on halt cycle", int'(adv_en), 0);
        cyc();
        chk("R8 halted after isr start", int'(halted), 1);
    endtask

    task automatic t_step();
        irq_req = 4'b0010; cyc(); clr();
        cmd_step = 1; step_int_en = 0; cyc(); clr(); #1;
        chk("R5 step adv_en", int'(adv_en), 1);
        chk("R6 step masks irq", int'(irq_grant), 0);
        cyc();
        chk("R5 waits for packet", int'(halted), 0);
        pkt_valid = 1; cyc(); clr();
        chk("R5 back in halt", int'(halted), 1);
        chk("R5 step_done pulse", int'(step_done), 1);
        cyc();
        chk("R5 step_done once", int'(step_done), 0);
        cmd_step = 1; step_int_en = 1; cyc(); clr(); step_int_en = 0; #1;
        chk("R6 step with enable grants", int'(irq_grant), 2);
        cyc();
        pkt_valid = 1; cyc(); clr();
        chk("R6 step returns", int'(halted), 1);
    endtask

    task automatic t_prio();
        irq_req = 4'b1010; cyc(); clr();
        go_run(); #1;
        chk("R12 lowest first", int'(irq_grant), 2);
        cyc();
        chk("R12 next source", int'(irq_grant), 8);
        cyc();
        chk("R12 drained", int'(irq_grant), 0);
        go_halt();
    endtask

    task automatic t_sync();
        sync_cfg = 1;
        go_run();
        chk("R10 wait not halted", int'(halted), 0);
        chk("R10 wait no adv", int'(adv_en), 0);
        cyc();
        chk("R10 still waiting", int'(adv_en), 0);
        sync_strobe = 1; cyc(); clr();
        chk("R10 runs after strobe", int'(adv_en), 1);
        go_halt();
        go_run();
        go_halt();
        chk("R11 halt from sync wait", int'(halted), 1);
        sync_cfg = 0;
        cmd_halt = 1; #1;
        chk("R11 halt in halt adv", int'(adv_en), 0);
        cyc(); clr();
        chk("R11 halt in halt stays", int'(halted), 1);
        chk("R11 halt in halt no done", int'(step_done), 0);
        cmd_step = 1; cyc(); clr();
        go_halt();
        chk("R11 halt from step", int'(halted), 1);
    endtask

    task automatic t_free();
        stop_en = 0;
        go_run();
        chk("R9 free entered", int'(halted), 0);
        ev_sw_bp = 1; ev_ext_trig = 1; #1;
        chk("R9 free ignores bp", int'(adv_en), 1);
        cyc(); clr();
        chk("R9 free stays running", int'(halted), 0);
        irq_req = 4'b0001; cyc(); clr(); #1;
        chk("R9 free serves irq", int'(irq_grant), 1);
        cyc();
        go_halt();
        chk("R11 halt from free", int'(halted), 1);
        stop_en = 1;
    endtask

    initial begin
        t_reset_free();
        t_reset_halt();
        t_halt_irq();
        t_break();
        t_collision();
        t_defer();
        t_step();
        t_prio();
        t_sync();
        t_free();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule